// File: doc/BRIEF.md
# Saturating Arithmetic Unit With Sticky Flag

This block performs 32-bit arithmetic that clamps at the edges of the number range instead of wrapping. A single 4-bit operation code picks one of nine functions: signed or unsigned add and subtract with clamping, a modular signed add that only reports overflow, and saturation of a signed value to a run-time bit position. That saturation limits the value to a signed range or to an unsigned range, and it works on either the full word or on two 16-bit lanes at once. The result is combinational from the inputs.

Any clamp seen while the `issue` strobe is high sets a registered sticky flag. The flag stays set across later operations that do not saturate, and only the dedicated `flag_clr` input clears it. This lets software run a whole sequence of operations and then check once whether any of them lost precision. Reset is asynchronous and active-low, and the block releases it through an internal two-stage synchronizer.

Top module: `sat_alu`

## Requirements
- R1: After reset, `sat_flag` reads 0.
- R2: Opcode 0 (signed add) returns the sum. When both operands have the same sign and the sum's sign differs, it instead returns 0x7FFFFFFF if `a` is non-negative and 0x80000000 if `a` is negative, and this counts as a clamp.
- R3: Opcode 1 (signed subtract, a-b) returns the difference. When the operands differ in sign and the difference's sign differs from `a`, it returns the same bounds as R2, chosen by the sign of `a`, and this counts as a clamp.
- R4: Opcode 2 (unsigned add) returns 0xFFFFFFFF, counted as a clamp, when the true sum needs more than 32 bits. Otherwise it returns the sum.
- R5: Opcode 3 (unsigned subtract) returns 0, counted as a clamp, when `b` > `a`. Otherwise it returns a-b.
- R6: Opcode 4 (wrapping add) always returns the 32-bit modular sum. Signed overflow, as defined in R2, counts as a clamp.
- R7: Opcode 5 (signed saturate) treats `a` as signed and limits it to the range -2^n .. 2^n-1, where n = `sat_pos` (0..31). It returns the bound that was exceeded, and exceeding a bound counts as a clamp.
- R8: Opcode 6 (unsigned saturate) treats `a` as signed. It returns 0 for negative input and 2^n-1 for input above 2^n-1, and both cases count as a clamp.
- R9: Opcodes 7 and 8 apply R7 and R8 respectively to each sign-extended 16-bit half of `a` on its own. The low 16 bits of each lane result go back into that lane (bits 15:0 and 31:16). A clamp in either lane counts.
- R10: A clamp while `issue` is 1 sets `sat_flag` at the next clock edge. An issued operation that does not clamp leaves the flag as it was.
- R11: `flag_clr` clears `sat_flag` at the next edge and has priority over a clamp in the same cycle.
- R12: Opcodes 9 to 15 return `a` unchanged and never change `sat_flag`.
- R13: With `issue` 0, no input pattern sets `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation strobe; enables a flag update |
| op | input | 4 | Operation code |
| a | input | 32 | First operand / value to saturate |
| b | input | 32 | Second operand (add and subtract only) |
| sat_pos | input | 5 | Saturation bit position n |
| flag_clr | input | 1 | Synchronous clear of the sticky flag |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The clocked properties sample `op`, `a`, `b` and `sat_pos` only in cycles where `issue` is 1. They therefore assume that these inputs are stable and known from before the sampling edge. The bench keeps to this by changing all inputs at the falling edge only and holding them through the following rising edge. The flag properties assume that `flag_clr` and `issue` are never X after reset. The bench drives both to known levels from time zero and pulses them for exactly one cycle each.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int DATA_W = 32;
  localparam int LANE_W = DATA_W / 2;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_UADD   = 4'd2,
    OP_USUB   = 4'd3,
    OP_WADD   = 4'd4,
    OP_SSAT   = 4'd5,
    OP_USAT   = 4'd6,
    OP_SSAT16 = 4'd7,
    OP_USAT16 = 4'd8
  } sat_op_e;
endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]   res,
  output logic           hit
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   sum_x;
  logic [W:0]   dif_x;
  logic         s_add_ovf;
  logic         s_sub_ovf;
  logic [W-1:0] s_bound;

  always_comb begin
    sum_x     = {1'b0, a} + {1'b0, b};
    dif_x     = {1'b0, a} - {1'b0, b};
    s_add_ovf = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
    s_sub_ovf = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
    s_bound   = a[W-1] ? NEG_MIN : POS_MAX;
  end

  always_comb begin
    res = a;
    hit = 1'b0;
    unique case (op)
      OP_SADD: begin
        hit = s_add_ovf;
        res = s_add_ovf ? s_bound : sum_x[W-1:0];
      end
      OP_SSUB: begin
        hit = s_sub_ovf;
        res = s_sub_ovf ? s_bound : dif_x[W-1:0];
      end
      OP_UADD: begin
        hit = sum_x[W];
        res = sum_x[W] ? {W{1'b1}} : sum_x[W-1:0];
      end
      OP_USUB: begin
        hit = dif_x[W];
        res = dif_x[W] ? '0 : dif_x[W-1:0];
      end
      OP_WADD: begin
        hit = s_add_ovf;
        res = sum_x[W-1:0];
      end
      default: begin
        res = a;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int W  = 32,
  parameter int PW = 5
) (
  input  logic [W-1:0]  val,
  input  logic [PW-1:0] pos,
  input  logic          uns,
  output logic [W-1:0]  res,
  output logic          hit
);
  logic signed [W-1:0] sval;
  logic signed [W-1:0] top;
  logic        [W-1:0] mask;

  always_comb begin
    sval = $signed(val);
    top  = sval >>> pos;
    mask = (W'(1) << pos) - W'(1);
  end

  always_comb begin
    res = val;
    hit = 1'b0;
    if (uns) begin
      if (sval < 0) begin
        res = '0;
        hit = 1'b1;
      end else if (val > mask) begin
        res = mask;
        hit = 1'b1;
      end
    end else begin
      if (top > 0) begin
        res = mask;
        hit = 1'b1;
      end else if (top < -1) begin
        res = ~mask;
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic upd;

  always_comb begin
    upd    = clr | (en & hit);
    flag_d = clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag_q);  // R11
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);  // R10
  AST_CLAMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && !clr) |=> flag_q);  // R10
  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !en) |=> !flag_q);  // R13
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [POS_W-1:0]  sat_pos,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] result,
  output logic              sat_flag
);
  localparam int NLANE = 2;

  logic              rst_n_i;
  logic [DATA_W-1:0] as_res;
  logic              as_hit;
  logic [DATA_W-1:0] wd_res;
  logic              wd_hit;
  logic              wd_uns;
  logic              ln_uns;
  logic [DATA_W-1:0] ln_in  [NLANE];
  logic [DATA_W-1:0] ln_res [NLANE];
  logic [NLANE-1:0]  ln_hit;
  logic [DATA_W-1:0] ln_pack;
  logic              is_arith;
  logic              is_word;
  logic              is_lane;
  logic              any_hit;

  sat_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  sat_addsub #(.W(DATA_W)) u_addsub (
    .a(a), .b(b), .op(op), .res(as_res), .hit(as_hit)
  );

  always_comb begin
    is_arith = (op <= OP_WADD);
    is_word  = (op == OP_SSAT) || (op == OP_USAT);
    is_lane  = (op == OP_SSAT16) || (op == OP_USAT16);
    wd_uns   = (op == OP_USAT);
    ln_uns   = (op == OP_USAT16);
  end

  sat_lane #(.W(DATA_W), .PW(POS_W)) u_word (
    .val(a), .pos(sat_pos), .uns(wd_uns), .res(wd_res), .hit(wd_hit)
  );

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    assign ln_in[gi] = {{(DATA_W-LANE_W){a[gi*LANE_W+LANE_W-1]}},
                        a[gi*LANE_W +: LANE_W]};
    sat_lane #(.W(DATA_W), .PW(POS_W)) u_half (
      .val(ln_in[gi]), .pos(sat_pos), .uns(ln_uns),
      .res(ln_res[gi]), .hit(ln_hit[gi])
    );
    assign ln_pack[gi*LANE_W +: LANE_W] = ln_res[gi][LANE_W-1:0];
  end

  always_comb begin
    result  = a;
    any_hit = 1'b0;
    if (is_arith) begin
      result  = as_res;
      any_hit = as_hit;
    end else if (is_word) begin
      result  = wd_res;
      any_hit = wd_hit;
    end else if (is_lane) begin
      result  = ln_pack;
      any_hit = |ln_hit;
    end
  end

  sat_sticky u_flag (
    .clk(clk), .rst_n(rst_n_i), .en(issue), .hit(any_hit),
    .clr(flag_clr), .flag(sat_flag)
  );

  AST_UADD_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && op == OP_UADD) |-> (result >= a));  // R4
  AST_USUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && op == OP_USUB) |-> (result <= a));  // R5
  AST_SSAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && op == OP_SSAT) |->
      ((($signed(result) >>> sat_pos) == 0) ||
       (($signed(result) >>> sat_pos) == -1)));  // R7
  AST_USAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && op == OP_USAT) |->
      ((result >> sat_pos) == '0));  // R8
  AST_WADD_MODULAR: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && op == OP_WADD) |-> (result - b == a));  // R6
  AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && op > OP_USAT16) |-> (result == a));  // R12
  AST_SPARE_FLAG: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue && op > OP_USAT16 && !flag_clr) |=> $stable(sat_flag));  // R12
endmodule

// File: tb/sim_sat_alu.sv
module sim_sat_alu;
  import sat_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [4:0]  sat_pos = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] result;
  logic        sat_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_flag = 1'b0;
  bit done = 1'b0;

  sat_alu u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .a(a), .b(b),
    .sat_pos(sat_pos), .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one operation, check the combinational result, then the flag after the edge.
  task automatic run_op(input string req, input logic [3:0] o, input logic [31:0] xa,
                        input logic [31:0] xb, input logic [4:0] n, input logic clr,
                        input logic go, input logic [31:0] exp_res, input logic exp_hit);
    @(negedge clk);
    op = o; a = xa; b = xb; sat_pos = n; flag_clr = clr; issue = go;
    #1;
    check(req, result, exp_res);
    if (clr) exp_flag = 1'b0;
    else if (go && exp_hit) exp_flag = 1'b1;
    @(negedge clk);
    issue = 1'b0; flag_clr = 1'b0;
    check(req, {31'd0, sat_flag}, {31'd0, exp_flag});
  endtask

  task automatic clear_flag();
    run_op("R11", 4'd15, 32'h0, 32'h0, 5'd0, 1'b1, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", {31'd0, sat_flag}, 32'd0);
  endtask

  task automatic t_sadd();
    run_op("R2", OP_SADD, 32'd5, 32'd3, 5'd0, 0, 1, 32'd8, 0);
    run_op("R2", OP_SADD, 32'h7FFF_FFFF, 32'd1, 5'd0, 0, 1, 32'h7FFF_FFFF, 1);
    clear_flag();
    run_op("R2", OP_SADD, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 0, 1, 32'h8000_0000, 1);
    clear_flag();
  endtask

  task automatic t_ssub();
    run_op("R3", OP_SSUB, 32'd10, 32'd3, 5'd0, 0, 1, 32'd7, 0);
    run_op("R3", OP_SSUB, 32'h8000_0000, 32'd1, 5'd0, 0, 1, 32'h8000_0000, 1);
    clear_flag();
    run_op("R3", OP_SSUB, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 0, 1, 32'h7FFF_FFFF, 1);
    clear_flag();
  endtask

  task automatic t_unsigned();
    run_op("R4", OP_UADD, 32'd1, 32'd2, 5'd0, 0, 1, 32'd3, 0);
    run_op("R4", OP_UADD, 32'hFFFF_FFF0, 32'h20, 5'd0, 0, 1, 32'hFFFF_FFFF, 1);
    clear_flag();
    run_op("R5", OP_USUB, 32'd9, 32'd4, 5'd0, 0, 1, 32'd5, 0);
    run_op("R5", OP_USUB, 32'd3, 32'd5, 5'd0, 0, 1, 32'd0, 1);
    clear_flag();
  endtask

  task automatic t_wadd();
    run_op("R6", OP_WADD, 32'd100, 32'd23, 5'd0, 0, 1, 32'd123, 0);
    run_op("R6", OP_WADD, 32'h7FFF_FFFF, 32'd1, 5'd0, 0, 1, 32'h8000_0000, 1);
    clear_flag();
  endtask

  task automatic t_word_sat();
    run_op("R7", OP_SSAT, 32'hFFFF_FFFB, 32'd0, 5'd7, 0, 1, 32'hFFFF_FFFB, 0);
    run_op("R7", OP_SSAT, 32'h0000_1000, 32'd0, 5'd7, 0, 1, 32'h0000_007F, 1);
    clear_flag();
    run_op("R7", OP_SSAT, 32'hFFFF_FC18, 32'd0, 5'd7, 0, 1, 32'hFFFF_FF80, 1);
    clear_flag();
    run_op("R7", OP_SSAT, 32'd5, 32'd0, 5'd0, 0, 1, 32'd0, 1);
    clear_flag();
    run_op("R8", OP_USAT, 32'd100, 32'd0, 5'd8, 0, 1, 32'd100, 0);
    run_op("R8", OP_USAT, 32'd300, 32'd0, 5'd8, 0, 1, 32'd255, 1);
    clear_flag();
    run_op("R8", OP_USAT, 32'hFFFF_FFFD, 32'd0, 5'd8, 0, 1, 32'd0, 1);
    clear_flag();
    run_op("R8", OP_USAT, 32'h7FFF_FFFF, 32'd0, 5'd31, 0, 1, 32'h7FFF_FFFF, 0);
  endtask

  task automatic t_lanes();
    run_op("R9", OP_SSAT16, 32'h0005_FFFE, 32'd0, 5'd7, 0, 1, 32'h0005_FFFE, 0);
    run_op("R9", OP_SSAT16, 32'h0100_FF00, 32'd0, 5'd7, 0, 1, 32'h007F_FF80, 1);
    clear_flag();
    run_op("R9", OP_USAT16, 32'h0100_8000, 32'd0, 5'd8, 0, 1, 32'h00FF_0000, 1);
    clear_flag();
    run_op("R9", OP_USAT16, 32'h0012_0034, 32'd0, 5'd8, 0, 1, 32'h0012_0034, 0);
  endtask

  task automatic t_sticky();
    run_op("R10", OP_UADD, 32'hFFFF_FFFF, 32'd1, 5'd0, 0, 1, 32'hFFFF_FFFF, 1);
    run_op("R10", OP_SADD, 32'd1, 32'd1, 5'd0, 0, 1, 32'd2, 0);
    run_op("R10", OP_USAT, 32'd7, 32'd0, 5'd4, 0, 1, 32'd7, 0);
    run_op("R11", OP_USUB, 32'd0, 32'd1, 5'd0, 1, 1, 32'd0, 1);
  endtask

  task automatic t_spare();
    run_op("R12", 4'd9, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 5'd0, 0, 1, 32'hDEAD_BEEF, 0);
    run_op("R12", 4'd15, 32'h8000_0000, 32'h8000_0000, 5'd3, 0, 1, 32'h8000_0000, 0);
    run_op("R10", OP_SSUB, 32'h8000_0000, 32'd1, 5'd0, 0, 1, 32'h8000_0000, 1);
    run_op("R12", 4'd12, 32'h1234_5678, 32'd0, 5'd0, 0, 1, 32'h1234_5678, 0);
    clear_flag();
  endtask

  task automatic t_idle();
    run_op("R13", OP_UADD, 32'hFFFF_FFFF, 32'd5, 5'd0, 0, 0, 32'hFFFF_FFFF, 1);
    run_op("R13", OP_SSAT, 32'h7000_0000, 32'd0, 5'd2, 0, 0, 32'd3, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sadd();
    t_ssub();
    t_unsigned();
    t_wadd();
    t_word_sat();
    t_lanes();
    t_sticky();
    t_spare();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule